// File: doc/BRIEF.md
# Batched Power-Gating Sequencer

This controller decides when the power domain of an accelerator may be switched off. Work tokens arrive as single-cycle strobes and are counted into a buffer. The accelerator is not started once per token. The sequencer waits until a programmable number `n` of tokens has built up, then launches the accelerator `n` times back to back. After that, the whole idle time of the batch falls into one long gap instead of many short ones.

When a batch ends, the sequencer checks whether the gap pays for gating. The combined idle time, `n` times the per-token idle cycles, must be strictly longer than the sum of five overhead estimates: state save, power ramp-down, power ramp-up, reconfiguration and state restore. A precomputed energy-break-even bit must also be set. If both hold, the domain goes through save, ramp-down, off, ramp-up, reconfigure and restore, in that order, and then returns to idle. The point at which ramp-up starts is chosen so that ramp-up, reconfiguration and restore all complete inside the idle window. If either condition fails, the accelerator stays powered and just idles.

Alongside this, a small iterative search reports the smallest batch size whose accumulated idle time exceeds the time overhead.

Top module: `pg_batch_sequencer`

## Requirements
- R1: After reset the outputs are as follows: `phase` = 0, `pwr_en` = 1, `busy` = 0, `tok_count` = 0, `ovf` = 0, and `accel_start`, `save_req`, `reconf_req`, `restore_req` are all 0.
- R2: `tok_count` rises by one for each cycle with `tok_in` high. It falls by one for each `accel_done` pulse accepted during a batch. If both happen in the same cycle, it is unchanged.
- R3: A batch launches when `phase` is idle and `tok_count` >= n, where n = `batch_n` and a value of 0 counts as 1. During the batch the block issues exactly n single-cycle `accel_start` pulses. Each pulse after the first follows the previous `accel_done` by one cycle. `tok_count` ends n lower.
- R4: When the last token of a batch is done, gating starts only if `energy_ok` = 1 and n*`idle_per_tok` is strictly greater than `est_save`+`cyc_down`+`cyc_up`+`est_reconf`+`est_restore`. Otherwise the block returns to idle with `pwr_en` held high.
- R5: `phase` encodes 0 idle, 1 run, 2 save, 3 ramp-down, 4 off, 5 ramp-up, 6 reconfigure, 7 restore. Gating always steps 2,3,4,5,6,7 and then returns to 0. Run leads only to 0 or 2.
- R6: `save_req`, `reconf_req` and `restore_req` are each high for the whole of their phase (2, 6 and 7 respectively). Each phase ends on the cycle after its matching done input is seen.
- R7: `pwr_en` is low exactly while `phase` is 3 or 4. `accel_start` only occurs while powered.
- R8: Ramp-down lasts max(`cyc_down`,1) cycles. Ramp-up lasts max(`cyc_up`,1) cycles.
- R9: Let W = n*`idle_per_tok` and L = `cyc_up`+`est_reconf`+`est_restore`. Ramp-up begins W-L+1 cycles after the save phase begins, provided the off phase has been reached by then.
- R10: Tokens arriving during any gating phase are still counted. An `accel_done` outside the run phase leaves `tok_count` unchanged.
- R11: `ovf` sets when `tok_count` exceeds `buf_max` and stays set until reset.
- R12: `busy` is high exactly while `phase` is 2 through 7.
- R13: `min_batch` settles to the smallest n >= 1 with n*`idle_per_tok` greater than the five-term overhead sum. It is capped at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_in | input | 1 | One token arrives this cycle |
| batch_n | input | CNT_W | Batch size n (0 acts as 1) |
| buf_max | input | CNT_W | Buffer limit for the overflow flag |
| idle_per_tok | input | TIME_W | Idle cycles per token |
| est_save | input | TIME_W | Estimated save duration |
| cyc_down | input | TIME_W | Ramp-down duration |
| cyc_up | input | TIME_W | Ramp-up duration |
| est_reconf | input | TIME_W | Estimated reconfiguration duration |
| est_restore | input | TIME_W | Estimated restore duration |
| energy_ok | input | 1 | Energy break-even reached for this batch size |
| accel_start | output | 1 | Start one token on the accelerator |
| accel_done | input | 1 | Accelerator finished a token |
| save_req | output | 1 | Request state save |
| save_done | input | 1 | State save finished |
| reconf_req | output | 1 | Request reconfiguration |
| reconf_done | input | 1 | Reconfiguration finished |
| restore_req | output | 1 | Request state restore |
| restore_done | input | 1 | State restore finished |
| pwr_en | output | 1 | Accelerator domain power enable |
| phase | output | 3 | Current phase code (R5) |
| busy | output | 1 | Gating sequence in progress |
| tok_count | output | CNT_W | Buffered tokens |
| ovf | output | 1 | Sticky buffer overflow |
| min_batch | output | CNT_W | Smallest worthwhile batch size |

## Verification
The bench aims at the strict comparison in the gating decision. With a window exactly equal to the overhead, a design using >= would power down where it must not. It times the off-to-ramp-up hand-off against the idle window, where an off-by-one in the countdown moves the wake edge by a cycle. It also measures ramp lengths, which a miscounted timer stretches or shortens. It injects tokens and a stray done during the off phase: a design that ignores arrivals while gated would lose a token, and one that accepts stray completions would drop a count. Random batches with varied sizes, idle times and energy bits check that the gating choice and the wake point follow the two conditions.

// File: rtl/pg_pkg.sv
// Shared phase encoding for the batched power-gating sequencer.
// The numeric codes appear on the phase output and must not be reordered.
package pg_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_RUN     = 3'd1,
        PH_SAVE    = 3'd2,
        PH_RDOWN   = 3'd3,
        PH_OFF     = 3'd4,
        PH_RUP     = 3'd5,
        PH_RECONF  = 3'd6,
        PH_RESTORE = 3'd7
    } pg_phase_e;
endpackage

// File: rtl/pg_tok_buffer.sv
// Token occupancy counter with a sticky overflow flag.
// Assumes at most one arrival and one removal per cycle; saturates at both ends.
module pg_tok_buffer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_in,
    input  logic             take,
    input  logic [CNT_W-1:0] buf_max,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP_C = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_nxt;

    // Next occupancy from arrivals and removals.
    always_comb begin
        cnt_nxt = count;
        if (tok_in && !take && count != TOP_C)
            cnt_nxt = count + ONE_C;
        else if (take && !tok_in && count != '0)
            cnt_nxt = count - ONE_C;
    end

    // Occupancy register and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            count <= cnt_nxt;
            ovf   <= ovf | (cnt_nxt > buf_max);
        end
    end
endmodule

// File: rtl/pg_gate_check.sv
// Gating profitability check and minimum-batch search.
// The combinational part compares the batch idle window with the summed overhead.
// The sequential part steps n upward until the accumulated idle time beats the overhead.
// Assumes CNT_W >= 3 so that the five-term sum fits in the product width.
module pg_gate_check #(
    parameter int CNT_W  = 8,
    parameter int TIME_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        n_eff,
    input  logic [TIME_W-1:0]       idle_per_tok,
    input  logic [TIME_W-1:0]       est_save,
    input  logic [TIME_W-1:0]       cyc_down,
    input  logic [TIME_W-1:0]       cyc_up,
    input  logic [TIME_W-1:0]       est_reconf,
    input  logic [TIME_W-1:0]       est_restore,
    input  logic                    energy_ok,
    output logic                    gate_ok,
    output logic [CNT_W+TIME_W-1:0] window,
    output logic [CNT_W+TIME_W-1:0] lead,
    output logic [CNT_W-1:0]        min_batch
);
    localparam int PROD_W = CNT_W + TIME_W;
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP_C = {CNT_W{1'b1}};

    logic [PROD_W-1:0] idle_x, ovh_sum;
    logic [CNT_W-1:0]  srch_n;
    logic [PROD_W-1:0] srch_acc;
    logic              srch_hit;

    // Widen the operands and form window, wake lead and total overhead.
    always_comb begin
        idle_x  = {{CNT_W{1'b0}}, idle_per_tok};
        window  = {{TIME_W{1'b0}}, n_eff} * idle_x;
        lead    = {{CNT_W{1'b0}}, cyc_up} + {{CNT_W{1'b0}}, est_reconf}
                + {{CNT_W{1'b0}}, est_restore};
        ovh_sum = lead + {{CNT_W{1'b0}}, est_save} + {{CNT_W{1'b0}}, cyc_down};
        gate_ok = energy_ok && (window > ovh_sum);
        srch_hit = (srch_n != '0) && ((srch_acc > ovh_sum) || (srch_n == TOP_C));
    end

    // Step the candidate batch size; latch and restart once it pays off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srch_n    <= '0;
            srch_acc  <= '0;
            min_batch <= '0;
        end else if (srch_hit) begin
            min_batch <= srch_n;
            srch_n    <= '0;
            srch_acc  <= '0;
        end else begin
            srch_n    <= srch_n + ONE_C;
            srch_acc  <= srch_acc + idle_x;
        end
    end
endmodule

// File: rtl/pg_phase_fsm.sv
// Phase sequencer: launches back-to-back batches and walks the power-down/up chain.
// An idle-window countdown, loaded at batch end, picks the wake point so that
// ramp-up, reconfiguration and restore fit before the window closes.
// Assumes done inputs are single-cycle pulses and accel_done never coincides with accel_start.
module pg_phase_fsm
    import pg_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TIME_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        count,
    input  logic [CNT_W-1:0]        n_eff,
    input  logic                    gate_ok,
    input  logic [CNT_W+TIME_W-1:0] window,
    input  logic [CNT_W+TIME_W-1:0] lead,
    input  logic [TIME_W-1:0]       cyc_down,
    input  logic [TIME_W-1:0]       cyc_up,
    input  logic                    accel_done,
    input  logic                    save_done,
    input  logic                    reconf_done,
    input  logic                    restore_done,
    output pg_phase_e               phase_q,
    output logic                    accel_start,
    output logic                    take
);
    localparam int PROD_W = CNT_W + TIME_W;
    localparam logic [CNT_W-1:0]  ONE_N = CNT_W'(1);
    localparam logic [TIME_W-1:0] ONE_T = TIME_W'(1);
    localparam logic [PROD_W-1:0] ONE_P = PROD_W'(1);

    logic [CNT_W-1:0]  left_q;
    logic [TIME_W-1:0] timer_q;
    logic [PROD_W-1:0] win_q;

    // A completion only consumes a token while a batch runs.
    assign take = (phase_q == PH_RUN) && accel_done;

    // Phase register, start pulse, batch countdown, ramp timer and idle window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            accel_start <= 1'b0;
            left_q      <= '0;
            timer_q     <= '0;
            win_q       <= '0;
        end else begin
            accel_start <= 1'b0;
            if (phase_q >= PH_SAVE && win_q != '0)
                win_q <= win_q - ONE_P;
            unique case (phase_q)
                PH_IDLE: if (count >= n_eff) begin
                    phase_q     <= PH_RUN;
                    accel_start <= 1'b1;
                    left_q      <= n_eff;
                end
                PH_RUN: if (accel_done) begin
                    if (left_q <= ONE_N) begin
                        if (gate_ok) begin
                            phase_q <= PH_SAVE;
                            win_q   <= window;
                        end else begin
                            phase_q <= PH_IDLE;
                        end
                    end else begin
                        left_q      <= left_q - ONE_N;
                        accel_start <= 1'b1;
                    end
                end
                PH_SAVE: if (save_done) begin
                    phase_q <= PH_RDOWN;
                    timer_q <= cyc_down;
                end
                PH_RDOWN: if (timer_q <= ONE_T) phase_q <= PH_OFF;
                          else timer_q <= timer_q - ONE_T;
                PH_OFF: if (win_q <= lead) begin
                    phase_q <= PH_RUP;
                    timer_q <= cyc_up;
                end
                PH_RUP: if (timer_q <= ONE_T) phase_q <= PH_RECONF;
                        else timer_q <= timer_q - ONE_T;
                PH_RECONF:  if (reconf_done)  phase_q <= PH_RESTORE;
                PH_RESTORE: if (restore_done) phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pg_batch_sequencer.sv
// Top of the batched accelerator power-gating sequencer.
// Ties the token buffer, the profitability check and the phase sequencer together
// and decodes the request, power and busy outputs from the phase.
module pg_batch_sequencer
    import pg_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TIME_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_in,
    input  logic [CNT_W-1:0]  batch_n,
    input  logic [CNT_W-1:0]  buf_max,
    input  logic [TIME_W-1:0] idle_per_tok,
    input  logic [TIME_W-1:0] est_save,
    input  logic [TIME_W-1:0] cyc_down,
    input  logic [TIME_W-1:0] cyc_up,
    input  logic [TIME_W-1:0] est_reconf,
    input  logic [TIME_W-1:0] est_restore,
    input  logic              energy_ok,
    output logic              accel_start,
    input  logic              accel_done,
    output logic              save_req,
    input  logic              save_done,
    output logic              reconf_req,
    input  logic              reconf_done,
    output logic              restore_req,
    input  logic              restore_done,
    output logic              pwr_en,
    output logic [2:0]        phase,
    output logic              busy,
    output logic [CNT_W-1:0]  tok_count,
    output logic              ovf,
    output logic [CNT_W-1:0]  min_batch
);
    localparam int PROD_W = CNT_W + TIME_W;

    logic [CNT_W-1:0]  n_eff;
    logic              gate_ok, take;
    logic [PROD_W-1:0] window, lead;
    pg_phase_e         phase_q;

    // A batch size of zero behaves as one.
    assign n_eff = (batch_n == '0) ? CNT_W'(1) : batch_n;

    pg_tok_buffer #(.CNT_W(CNT_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .take(take),
        .buf_max(buf_max), .count(tok_count), .ovf(ovf)
    );

    pg_gate_check #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .n_eff(n_eff), .idle_per_tok(idle_per_tok),
        .est_save(est_save), .cyc_down(cyc_down), .cyc_up(cyc_up),
        .est_reconf(est_reconf), .est_restore(est_restore), .energy_ok(energy_ok),
        .gate_ok(gate_ok), .window(window), .lead(lead), .min_batch(min_batch)
    );

    pg_phase_fsm #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .count(tok_count), .n_eff(n_eff),
        .gate_ok(gate_ok), .window(window), .lead(lead),
        .cyc_down(cyc_down), .cyc_up(cyc_up), .accel_done(accel_done),
        .save_done(save_done), .reconf_done(reconf_done), .restore_done(restore_done),
        .phase_q(phase_q), .accel_start(accel_start), .take(take)
    );

    // Phase-decoded outputs.
    always_comb begin
        phase       = phase_q;
        save_req    = (phase_q == PH_SAVE);
        reconf_req  = (phase_q == PH_RECONF);
        restore_req = (phase_q == PH_RESTORE);
        pwr_en      = !(phase_q == PH_RDOWN || phase_q == PH_OFF);
        busy        = (phase_q >= PH_SAVE);
    end
endmodule

// File: rtl/pg_batch_sequencer_chk.sv
// Temporal checks on the sequencer, attached to every instance by bind.
// Assumes the phase codes of pg_pkg.
module pg_batch_sequencer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       phase,
    input logic             accel_start,
    input logic             pwr_en,
    input logic             ovf,
    input logic [CNT_W-1:0] tok_count,
    input logic             save_req,
    input logic             reconf_req,
    input logic             restore_req,
    input logic             gate_ok
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    // True when moving from prev to cur is a permitted step.
    function automatic logic step_ok(input logic [2:0] prev, input logic [2:0] cur);
        case (prev)
            3'd0:    return cur == 3'd1;
            3'd1:    return cur == 3'd0 || cur == 3'd2;
            3'd7:    return cur == 3'd0;
            default: return cur == prev + 3'd1;
        endcase
    endfunction

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> step_ok($past(phase), phase)); // R5
    AST_START_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        accel_start |-> (phase == 3'd1)); // R3
    AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        accel_start |-> pwr_en); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf) |-> ovf); // R11
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_count == $past(tok_count)) || (tok_count == $past(tok_count) + ONE_C)
        || (tok_count == $past(tok_count) - ONE_C)); // R2
    AST_GATE_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd1 && phase == 3'd2) |-> $past(gate_ok)); // R4
    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_req, reconf_req, restore_req, accel_start})); // R6
endmodule

bind pg_batch_sequencer pg_batch_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase(phase), .accel_start(accel_start),
    .pwr_en(pwr_en), .ovf(ovf), .tok_count(tok_count), .save_req(save_req),
    .reconf_req(reconf_req), .restore_req(restore_req), .gate_ok(gate_ok)
);

// File: tb/pg_batch_sequencer_tb.sv
// Self-checking bench: directed corner cases plus seeded random batches.
module pg_batch_sequencer_tb;
    localparam int CNT_W  = 8;
    localparam int TIME_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_in = 1'b0;
    logic [CNT_W-1:0]  batch_n = '0, buf_max = 8'd200;
    logic [TIME_W-1:0] idle_per_tok = '0;
    logic [TIME_W-1:0] est_save = 24'd2, cyc_down = 24'd5, cyc_up = 24'd4;
    logic [TIME_W-1:0] est_reconf = 24'd6, est_restore = 24'd3;
    logic energy_ok = 1'b0;
    logic accel_start, accel_done, save_req, reconf_req, restore_req, pwr_en, busy, ovf;
    logic save_done = 1'b0, reconf_done = 1'b0, restore_done = 1'b0;
    logic acc_resp = 1'b0, done_inj = 1'b0, start_seen = 1'b0;
    logic [2:0] phase;
    logic [CNT_W-1:0] tok_count, min_batch;

    int n_checks = 0, n_err = 0;
    bit finished = 0;
    int ncyc = 0;
    logic [2:0] prev_ph = 3'd0;
    int t_enter [8];
    int starts = 0, saw_save = 0, pwr_low = 0;
    int bad_busy = 0, bad_pwr = 0, bad_order = 0, bad_req = 0;

    assign accel_done = acc_resp | done_inj;

    always #2 clk = ~clk;

    pg_batch_sequencer #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .batch_n(batch_n), .buf_max(buf_max),
        .idle_per_tok(idle_per_tok), .est_save(est_save), .cyc_down(cyc_down),
        .cyc_up(cyc_up), .est_reconf(est_reconf), .est_restore(est_restore),
        .energy_ok(energy_ok), .accel_start(accel_start), .accel_done(accel_done),
        .save_req(save_req), .save_done(save_done), .reconf_req(reconf_req),
        .reconf_done(reconf_done), .restore_req(restore_req), .restore_done(restore_done),
        .pwr_en(pwr_en), .phase(phase), .busy(busy), .tok_count(tok_count),
        .ovf(ovf), .min_batch(min_batch)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference for the minimum worthwhile batch size (R13).
    function automatic int exp_min(input int idle, input int ovh);
        for (int n = 1; n < 255; n++) if (n * idle > ovh) return n;
        return 255;
    endfunction

    function automatic logic legal(input logic [2:0] p, input logic [2:0] c);
        if (p == 3'd0) return c == 3'd1;
        if (p == 3'd1) return c == 3'd0 || c == 3'd2;
        if (p == 3'd7) return c == 3'd0;
        return c == p + 3'd1;
    endfunction

    // Accelerator model: done one cycle after each start is seen.
    initial forever begin
        @(negedge clk);
        acc_resp   = start_seen;
        start_seen = accel_start;
    end

    // Save, reconfigure and restore responders: one-cycle done per request.
    initial forever begin
        @(negedge clk);
        save_done    = save_req & ~save_done;
        reconf_done  = reconf_req & ~reconf_done;
        restore_done = restore_req & ~restore_done;
    end

    // Cycle monitor for phase order, power enable, busy and request levels.
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            ncyc++;
            if (phase != prev_ph) begin
                if (!legal(prev_ph, phase)) bad_order++;
                t_enter[phase] = ncyc;
            end
            prev_ph = phase;
            if (accel_start) starts++;
            if (phase == 3'd2) saw_save = 1;
            if (!pwr_en) pwr_low++;
            if (busy != (phase >= 3'd2)) bad_busy++;
            if (pwr_en != !(phase == 3'd3 || phase == 3'd4)) bad_pwr++;
            if (save_req != (phase == 3'd2) || reconf_req != (phase == 3'd6)
                || restore_req != (phase == 3'd7)) bad_req++;
        end
    end

    task automatic send_tokens(input int k);
        repeat (k) begin
            @(negedge clk); tok_in = 1'b1;
            @(negedge clk); tok_in = 1'b0;
        end
    endtask

    task automatic clear_marks();
        starts = 0; saw_save = 0; pwr_low = 0;
    endtask

    task automatic wait_batch();
        wait (phase == 3'd1);
        wait (phase == 3'd0);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(phase == 3'd0, "R1 phase", phase, 0);
        chk(pwr_en == 1'b1 && busy == 1'b0, "R1 pwr_en/busy", {pwr_en, busy}, 2);
        chk(tok_count == 0 && ovf == 0, "R1 count/ovf", tok_count + ovf, 0);
        chk({accel_start, save_req, reconf_req, restore_req} == 4'b0, "R1 requests",
            {accel_start, save_req, reconf_req, restore_req}, 0);
        rst_n = 1'b1;

        // R13: minimum batch search
        idle_per_tok = 24'd10;
        repeat (30) @(negedge clk);
        chk(min_batch == exp_min(10, 20), "R13 idle 10", min_batch, exp_min(10, 20));
        idle_per_tok = 24'd7;
        repeat (30) @(negedge clk);
        chk(min_batch == exp_min(7, 20), "R13 idle 7", min_batch, exp_min(7, 20));
        idle_per_tok = 24'd0;
        repeat (700) @(negedge clk);
        chk(min_batch == 255, "R13 cap", min_batch, 255);

        // R2, R3, R4, R7: batch without energy permission
        batch_n = 8'd3; idle_per_tok = 24'd15; energy_ok = 1'b0;
        send_tokens(2);
        @(negedge clk);
        chk(tok_count == 2, "R2 count", tok_count, 2);
        chk(phase == 3'd0, "R3 waits for n", phase, 0);
        clear_marks();
        send_tokens(1);
        wait_batch();
        chk(starts == 3, "R3 start pulses", starts, 3);
        chk(tok_count == 0, "R3 count drained", tok_count, 0);
        chk(saw_save == 0, "R4 no energy", saw_save, 0);
        chk(pwr_low == 0, "R7 stays powered", pwr_low, 0);

        // R4: window equal to overhead does not gate
        energy_ok = 1'b1; batch_n = 8'd2; idle_per_tok = 24'd10;
        clear_marks();
        send_tokens(2);
        wait_batch();
        chk(saw_save == 0, "R4 equal window", saw_save, 0);

        // R4, R5, R8, R9, R10: gated batch, tokens and stray done while off
        idle_per_tok = 24'd15;
        clear_marks();
        send_tokens(2);
        wait (phase == 3'd4);
        @(negedge clk); tok_in = 1'b1;
        @(negedge clk); tok_in = 1'b0;
        @(negedge clk); done_inj = 1'b1;
        @(negedge clk); done_inj = 1'b0;
        chk(phase == 3'd4 && tok_count == 1, "R10 token while off", tok_count, 1);
        wait (phase == 3'd0);
        repeat (3) @(negedge clk);
        chk(saw_save == 1, "R4 gated", saw_save, 1);
        chk(t_enter[4] - t_enter[3] == 5, "R8 ramp-down", t_enter[4] - t_enter[3], 5);
        chk(t_enter[6] - t_enter[5] == 4, "R8 ramp-up", t_enter[6] - t_enter[5], 4);
        chk(t_enter[5] - t_enter[2] == 30 - 13 + 1, "R9 wake point",
            t_enter[5] - t_enter[2], 18);
        chk(t_enter[0] > t_enter[7] && t_enter[7] > t_enter[6], "R5 tail order",
            t_enter[7] - t_enter[6], 1);
        chk(tok_count == 1, "R10 stray done ignored", tok_count, 1);

        // R4, R9: single-token batch just above the overhead
        idle_per_tok = 24'd21;
        clear_marks();
        batch_n = 8'd1;
        wait_batch();
        chk(saw_save == 1, "R4 one above", saw_save, 1);
        chk(t_enter[5] - t_enter[2] == 21 - 13 + 1, "R9 short window",
            t_enter[5] - t_enter[2], 9);

        // R3: batch size zero acts as one
        energy_ok = 1'b0; batch_n = 8'd0;
        clear_marks();
        send_tokens(1);
        wait_batch();
        chk(starts == 1 && tok_count == 0, "R3 zero as one", starts, 1);

        // R11: overflow above limit, sticky
        batch_n = 8'd200; buf_max = 8'd4;
        send_tokens(4);
        @(negedge clk);
        chk(ovf == 1'b0, "R11 at limit", ovf, 0);
        send_tokens(1);
        @(negedge clk);
        chk(ovf == 1'b1, "R11 above limit", ovf, 1);
        batch_n = 8'd5;
        wait_batch();
        chk(ovf == 1'b1 && tok_count == 0, "R11 sticky", ovf, 1);
        buf_max = 8'd200;

        // R4, R9: random batches
        for (int i = 0; i < 8; i++) begin
            int n, idl, w;
            bit en, exp_g;
            n   = $urandom_range(1, 3);
            idl = $urandom_range(5, 20);
            en  = $urandom_range(0, 1);
            w   = n * idl;
            exp_g = en && (w > 20);
            energy_ok = en; idle_per_tok = TIME_W'(idl); batch_n = CNT_W'(n);
            clear_marks();
            send_tokens(n);
            wait_batch();
            chk(saw_save == int'(exp_g), "R4 random decision", saw_save, exp_g);
            chk(starts == n, "R3 random starts", starts, n);
            if (exp_g)
                chk(t_enter[5] - t_enter[2] == w - 12, "R9 random wake",
                    t_enter[5] - t_enter[2], w - 12);
        end

        // Cycle-wise monitors
        chk(bad_order == 0, "R5 phase order", bad_order, 0);
        chk(bad_req == 0, "R6 request levels", bad_req, 0);
        chk(bad_pwr == 0, "R7 power enable", bad_pwr, 0);
        chk(bad_busy == 0, "R12 busy", bad_busy, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule